// File: doc/BRIEF.md
# Length-Prefixed Packet Framer and Checker

This block puts packets into frames for a shared-memory link and checks frames that come back. On the transmit side it takes a 32-bit length command and a byte stream. It first emits the length as a four-byte header with the most significant byte first, then forwards the payload bytes. When the packet's protocol version asks for integrity protection, it ends the frame with a four-byte CRC, also with the most significant byte first. The header length counts only payload bytes and never the trailer.

The receive side consumes frames of the same shape. It takes in the header, forwards exactly the announced number of payload bytes, and, for protected frames, compares the received trailer with a CRC it computes itself. At the end of every frame it raises a one-cycle completion pulse together with a mismatch flag.

All data paths are byte-wide valid/ready streams. The version input selects the frame format. Version 3 adds the trailer. Versions 1 and 2 carry none.

Top module: `pf_framer`

## Requirements
- R1: After a length command is accepted, the transmit output first carries the 32-bit length as four bytes, most significant byte first.
- R2: The transmit output forwards exactly the commanded number of payload bytes, unchanged and in order, directly after the header.
- R3: With version value 3, four trailer bytes follow the payload, most significant byte first. They hold the CRC over the payload: reflected polynomial 0xEDB88320, bytes taken LSB first, register seeded with 0xFFFFFFFF, result inverted. The payload "123456789" gives the trailer CB F4 39 26.
- R4: With any version value other than 3, the frame ends after the last payload byte, and no further transmit byte is offered.
- R5: A zero length produces only the header. With version 3 it produces the header followed by the trailer 00 00 00 00.
- R6: While txOutReady is low, a header or trailer byte on the output stays valid and unchanged, and the payload input is not accepted. No byte is lost or reordered.
- R7: The transmit version is captured when the length is accepted. A later change on the version input does not alter that frame.
- R8: The receive side consumes the header and trailer without showing them at its output. It forwards exactly the announced number of payload bytes, in order.
- R9: rxDone is high for exactly one cycle: the cycle after the final byte of a frame is accepted. The final byte is the last trailer byte for version 3. Otherwise it is the last payload byte, or the last header byte when the length is zero.
- R10: rxCrcErr is high with rxDone exactly when the frame is version 3 and its trailer differs from the recomputed CRC. It is low at all other times.
- R11: During the receive payload, rxInReady follows rxOutReady, so backpressure on the receive output stalls the input.
- R12: After reset txLenReady is high, and txOutValid, rxOutValid and rxDone are low. txLenReady is low from the accepted command until the frame has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| version | input | 2 | Protocol version; value 3 selects the CRC trailer |
| txLenValid | input | 1 | Length command valid |
| txLenReady | output | 1 | Framer idle and ready for a command |
| txLen | input | 32 | Payload length in bytes |
| txInValid | input | 1 | Transmit payload byte valid |
| txInReady | output | 1 | Transmit payload byte accepted |
| txInData | input | 8 | Transmit payload byte |
| txOutValid | output | 1 | Framed byte valid |
| txOutReady | input | 1 | Downstream accepts framed byte |
| txOutData | output | 8 | Framed byte |
| rxInValid | input | 1 | Received frame byte valid |
| rxInReady | output | 1 | Received frame byte accepted |
| rxInData | input | 8 | Received frame byte |
| rxOutValid | output | 1 | Recovered payload byte valid |
| rxOutReady | input | 1 | Downstream accepts payload byte |
| rxOutData | output | 8 | Recovered payload byte |
| rxDone | output | 1 | One-cycle end-of-frame pulse |
| rxCrcErr | output | 1 | Trailer mismatch, valid with rxDone |

## Verification
The last payload byte can pass in the same cycle that the trailer register is loaded. The CRC update for that byte and the capture of the inverted result then coincide, and at zero length the header end and the trailer load coincide in the same way. Single-byte and empty version-3 packets force this overlap, and stalls placed near the boundary move it around. The bench judges it by comparing the emitted trailer bytes with a CRC computed independently, and against fixed known values. On the receive side the last trailer byte arrives in the same cycle as the comparison that sets the mismatch flag. Frames with a flipped trailer bit must raise rxCrcErr exactly with rxDone, and clean frames must leave it low.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int SUB_W      = $clog2(WORD_BYTES);
  localparam logic [WORD_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_PAY, TX_TRL} txState_t;
  typedef enum logic [1:0] {RX_HDR, RX_PAY, RX_TRL} rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;    // length command accepted
    logic txMeta;    // header or trailer byte left
    logic txPay;     // payload byte moved
    logic txTrl;     // capture inverted CRC as trailer
    logic txPaySel;  // level: payload phase on transmit
    logic rxHdr;     // header byte taken
    logic rxPay;     // payload byte moved
    logic rxTrl;     // trailer byte taken
  } pfStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic txSubLast;
    logic txCntZero;
    logic txCntOne;
    logic rxSubLast;
    logic rxLenZero;
    logic rxCntOne;
    logic rxCrcOk;
  } pfStatus_t;

  function automatic logic [WORD_W-1:0] crcByte(logic [WORD_W-1:0] crcIn,
                                                logic [BYTE_W-1:0] dataIn);
    logic [WORD_W-1:0] acc;
    acc = crcIn ^ {{(WORD_W-BYTE_W){1'b0}}, dataIn};
    for (int b = 0; b < BYTE_W; b++) begin
      acc = acc[0] ? ((acc >> 1) ^ CRC_POLY) : (acc >> 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/pf_datapath.sv
module pf_datapath
  import pf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  pfStrobe_t             strb,
  input  logic [WORD_W-1:0]     txLen,
  input  logic [BYTE_W-1:0]     txInData,
  input  logic [BYTE_W-1:0]     rxInData,
  output logic [BYTE_W-1:0]     txOutData,
  output logic [BYTE_W-1:0]     rxOutData,
  output pfStatus_t             stat
);
  logic [WORD_W-1:0] txWord, txCnt, txCrc, txCrcNext;
  logic [WORD_W-1:0] rxWord, rxCnt, rxCrc, rxWordNext;
  logic [SUB_W-1:0]  txSub, rxSub;

  assign txCrcNext  = crcByte(txCrc, txInData);
  assign rxWordNext = {rxWord[WORD_W-BYTE_W-1:0], rxInData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord <= '0;
      txCnt  <= '0;
      txCrc  <= CRC_SEED;
      txSub  <= '0;
    end else if (strb.txLoad) begin
      txWord <= txLen;
      txCnt  <= txLen;
      txCrc  <= CRC_SEED;
      txSub  <= '0;
    end else begin
      if (strb.txMeta) begin
        txWord <= txWord << BYTE_W;
        txSub  <= txSub + 1'b1;
      end
      if (strb.txPay) begin
        txCnt <= txCnt - 1'b1;
        txCrc <= txCrcNext;
      end
      if (strb.txTrl) txWord <= ~(strb.txPay ? txCrcNext : txCrc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWord <= '0;
      rxCnt  <= '0;
      rxCrc  <= CRC_SEED;
      rxSub  <= '0;
    end else begin
      if (strb.rxHdr || strb.rxTrl) begin
        rxWord <= rxWordNext;
        rxSub  <= rxSub + 1'b1;
      end
      if (strb.rxHdr && stat.rxSubLast) begin
        rxCnt <= rxWordNext;
        rxCrc <= CRC_SEED;
      end
      if (strb.rxPay) begin
        rxCnt <= rxCnt - 1'b1;
        rxCrc <= crcByte(rxCrc, rxInData);
      end
    end
  end

  assign txOutData = strb.txPaySel ? txInData : txWord[WORD_W-1 -: BYTE_W];
  assign rxOutData = rxInData;

  always_comb begin
    stat.txSubLast = (txSub == SUB_W'(WORD_BYTES - 1));
    stat.txCntZero = (txCnt == '0);
    stat.txCntOne  = (txCnt == WORD_W'(1));
    stat.rxSubLast = (rxSub == SUB_W'(WORD_BYTES - 1));
    stat.rxLenZero = (rxWordNext == '0);
    stat.rxCntOne  = (rxCnt == WORD_W'(1));
    stat.rxCrcOk   = (rxWordNext == ~rxCrc);
  end

  // R3: every new transmit packet starts its CRC from the all-ones seed
  a_r3_crc_seed: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> (txCrc == CRC_SEED));
  // R2: each forwarded payload byte takes exactly one off the remaining count
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.txPay |=> (txCnt == $past(txCnt) - WORD_W'(1)));
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int VER_W   = 2,
  parameter int CRC_VER = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VER_W-1:0] version,
  input  logic             txLenValid,
  output logic             txLenReady,
  input  logic             txInValid,
  output logic             txInReady,
  output logic             txOutValid,
  input  logic             txOutReady,
  input  logic             rxInValid,
  output logic             rxInReady,
  output logic             rxOutValid,
  input  logic             rxOutReady,
  output logic             rxDone,
  output logic             rxCrcErr,
  input  pfStatus_t        stat,
  output pfStrobe_t        strb
);
  txState_t txSt;
  rxState_t rxSt;
  logic txV3, rxV3, verIsCrc;
  logic txFire, rxFire, rxHdrEnd, doneNext, errNext;

  assign verIsCrc = (version == VER_W'(CRC_VER));

  always_comb begin
    txLenReady = (txSt == TX_IDLE);
    txOutValid = (txSt == TX_HDR) || (txSt == TX_TRL) || ((txSt == TX_PAY) && txInValid);
    txInReady  = (txSt == TX_PAY) && txOutReady;
    txFire     = txOutValid && txOutReady;
    rxInReady  = (rxSt == RX_PAY) ? rxOutReady : 1'b1;
    rxOutValid = (rxSt == RX_PAY) && rxInValid;
    rxFire     = rxInValid && rxInReady;

    strb.txLoad   = txLenValid && txLenReady;
    strb.txMeta   = txFire && ((txSt == TX_HDR) || (txSt == TX_TRL));
    strb.txPay    = txFire && (txSt == TX_PAY);
    strb.txPaySel = (txSt == TX_PAY);
    strb.txTrl    = txV3 && ((txFire && (txSt == TX_HDR) && stat.txSubLast && stat.txCntZero)
                          || (strb.txPay && stat.txCntOne));
    strb.rxHdr    = rxFire && (rxSt == RX_HDR);
    strb.rxPay    = rxFire && (rxSt == RX_PAY);
    strb.rxTrl    = rxFire && (rxSt == RX_TRL);

    rxHdrEnd = strb.rxHdr && stat.rxSubLast;
    doneNext = (rxHdrEnd && stat.rxLenZero && !verIsCrc)
            || (strb.rxPay && stat.rxCntOne && !rxV3)
            || (strb.rxTrl && stat.rxSubLast);
    errNext  = strb.rxTrl && stat.rxSubLast && !stat.rxCrcOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSt <= TX_IDLE;
      txV3 <= 1'b0;
    end else begin
      case (txSt)
        TX_IDLE: if (strb.txLoad) begin
          txSt <= TX_HDR;
          txV3 <= verIsCrc;
        end
        TX_HDR: if (txFire && stat.txSubLast)
          txSt <= !stat.txCntZero ? TX_PAY : (txV3 ? TX_TRL : TX_IDLE);
        TX_PAY: if (strb.txPay && stat.txCntOne)
          txSt <= txV3 ? TX_TRL : TX_IDLE;
        default: if (txFire && stat.txSubLast) txSt <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSt     <= RX_HDR;
      rxV3     <= 1'b0;
      rxDone   <= 1'b0;
      rxCrcErr <= 1'b0;
    end else begin
      rxDone   <= doneNext;
      rxCrcErr <= errNext;
      case (rxSt)
        RX_HDR: if (rxHdrEnd) begin
          rxV3 <= verIsCrc;
          rxSt <= !stat.rxLenZero ? RX_PAY : (verIsCrc ? RX_TRL : RX_HDR);
        end
        RX_PAY: if (strb.rxPay && stat.rxCntOne)
          rxSt <= rxV3 ? RX_TRL : RX_HDR;
        default: if (strb.rxTrl && stat.rxSubLast) rxSt <= RX_HDR;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);
  // R10: the mismatch flag only appears together with completion
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rxCrcErr |-> rxDone);
  // R12: an accepted command makes the framer busy
  a_r12_busy_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (txLenValid && txLenReady) |=> !txLenReady);
endmodule

// File: rtl/pf_framer.sv
module pf_framer
  import pf_pkg::*;
#(
  parameter int VER_W   = 2,
  parameter int CRC_VER = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VER_W-1:0] version,
  input  logic             txLenValid,
  output logic             txLenReady,
  input  logic [31:0]      txLen,
  input  logic             txInValid,
  output logic             txInReady,
  input  logic [7:0]       txInData,
  output logic             txOutValid,
  input  logic             txOutReady,
  output logic [7:0]       txOutData,
  input  logic             rxInValid,
  output logic             rxInReady,
  input  logic [7:0]       rxInData,
  output logic             rxOutValid,
  input  logic             rxOutReady,
  output logic [7:0]       rxOutData,
  output logic             rxDone,
  output logic             rxCrcErr
);
  pfStrobe_t strb;
  pfStatus_t stat;

  pf_ctrl #(.VER_W(VER_W), .CRC_VER(CRC_VER)) uCtrl (
    .clk(clk), .rstN(rstN), .version(version),
    .txLenValid(txLenValid), .txLenReady(txLenReady),
    .txInValid(txInValid), .txInReady(txInReady),
    .txOutValid(txOutValid), .txOutReady(txOutReady),
    .rxInValid(rxInValid), .rxInReady(rxInReady),
    .rxOutValid(rxOutValid), .rxOutReady(rxOutReady),
    .rxDone(rxDone), .rxCrcErr(rxCrcErr),
    .stat(stat), .strb(strb)
  );

  pf_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .txLen(txLen),
    .txInData(txInData), .rxInData(rxInData),
    .txOutData(txOutData), .rxOutData(rxOutData), .stat(stat)
  );

  // R6: a stalled header or trailer byte is held steady
  a_r6_meta_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txOutValid && !txOutReady && !strb.txPaySel) |=> (txOutValid && $stable(txOutData)));
endmodule

// File: tb/tb_pf_framer.sv
module tb_pf_framer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN;
  logic [1:0] version;
  logic       txLenValid, txLenReady, txInValid, txInReady, txOutValid, txOutReady;
  logic [31:0] txLen;
  logic [7:0] txInData, txOutData, rxInData, rxOutData;
  logic       rxInValid, rxInReady, rxOutValid, rxOutReady, rxDone, rxCrcErr;

  pf_framer dut (
    .clk(clk), .rstN(rstN), .version(version),
    .txLenValid(txLenValid), .txLenReady(txLenReady), .txLen(txLen),
    .txInValid(txInValid), .txInReady(txInReady), .txInData(txInData),
    .txOutValid(txOutValid), .txOutReady(txOutReady), .txOutData(txOutData),
    .rxInValid(rxInValid), .rxInReady(rxInReady), .rxInData(rxInData),
    .rxOutValid(rxOutValid), .rxOutReady(rxOutReady), .rxOutData(rxOutData),
    .rxDone(rxDone), .rxCrcErr(rxCrcErr)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  typedef struct packed {
    logic [1:0] ver;
    logic [7:0] len;
    logic [7:0] seed;
    logic [7:0] step;
    logic       bp;
    logic       corrupt;
    logic       flip;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{2'd3, 8'd9,  8'h31, 8'd1,  1'b0, 1'b0, 1'b0},
    '{2'd1, 8'd5,  8'h10, 8'd3,  1'b1, 1'b0, 1'b0},
    '{2'd2, 8'd0,  8'h00, 8'd0,  1'b0, 1'b0, 1'b0},
    '{2'd3, 8'd0,  8'h00, 8'd0,  1'b1, 1'b0, 1'b0},
    '{2'd3, 8'd17, 8'hA5, 8'd7,  1'b1, 1'b1, 1'b0},
    '{2'd3, 8'd12, 8'h00, 8'h13, 1'b0, 1'b0, 1'b1},
    '{2'd2, 8'd3,  8'hFF, 8'd1,  1'b1, 1'b0, 1'b0},
    '{2'd3, 8'd1,  8'h5A, 8'd0,  1'b1, 1'b1, 1'b0}
  };

  logic [7:0] pay [64];
  logic [7:0] frame [80];
  logic [7:0] cap [80];
  logic [7:0] rcap [64];
  int flen;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, pay[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic buildFrame(input vec_t v);
    logic [31:0] crc;
    for (int i = 0; i < int'(v.len); i++) pay[i] = v.seed + 8'(i) * v.step;
    frame[0] = 8'd0; frame[1] = 8'd0; frame[2] = 8'd0; frame[3] = v.len;
    for (int i = 0; i < int'(v.len); i++) frame[4+i] = pay[i];
    flen = 4 + int'(v.len);
    if (v.ver == 2'd3) begin
      crc = refCrc(int'(v.len));
      for (int k = 0; k < 4; k++) frame[flen+k] = crc[31-8*k -: 8];
      flen += 4;
    end
  endtask

  task automatic runTx(input vec_t v, input int idx);
    int pi, ci, busyViol, stallViol;
    bit okAll;
    pi = 0; ci = 0; busyViol = 0; stallViol = 0;
    @(negedge clk);
    version = v.ver; txLen = {24'd0, v.len}; txLenValid = 1'b1;
    #1;
    chk(txLenReady == 1'b1, "R12", "idle ready before command", txLenReady, 1);
    for (int c = 0; c < 600 && ci < flen; c++) begin
      @(negedge clk);
      txLenValid = 1'b0;
      if (v.flip) version = 2'd1;
      txInValid  = (pi < int'(v.len)) && !(v.bp && (c % 4 == 1));
      txInData   = pay[pi];
      txOutReady = !(v.bp && (((c + int'(v.seed)) % 3) == 0));
      #1;
      if (txLenReady) busyViol++;
      if (!txOutReady && txInReady) stallViol++;
      if (txInValid && txInReady) pi++;
      if (txOutValid && txOutReady) begin cap[ci] = txOutData; ci++; end
    end
    @(negedge clk);
    txInValid = 1'b0; txOutReady = 1'b1;
    #1;
    chk(ci == flen, "R2", "frame byte count", ci, flen);
    chk(txOutValid == 1'b0, (v.ver == 2'd3) ? "R3" : "R4", "no byte after frame", txOutValid, 0);
    chk(busyViol == 0, "R12", "busy while sending", busyViol, 0);
    chk(stallViol == 0, "R6", "payload taken while stalled", stallViol, 0);
    chk(txLenReady == 1'b1, "R12", "idle after frame", txLenReady, 1);
    okAll = 1'b1;
    for (int k = 0; k < 4; k++) if (cap[k] !== frame[k]) okAll = 1'b0;
    chk(okAll, "R1", "header bytes", {cap[0], cap[1], cap[2], cap[3]},
        {frame[0], frame[1], frame[2], frame[3]});
    okAll = 1'b1;
    for (int k = 4; k < flen; k++) if (cap[k] !== frame[k]) begin
      okAll = 1'b0;
      $display("FAIL R2 vec%0d byte %0d: actual=%0h expected=%0h", idx, k, cap[k], frame[k]);
    end
    chk(okAll, v.flip ? "R7" : "R2", "payload and trailer bytes", okAll, 1);
    if (idx == 0)  // R3 known value
      chk({cap[13], cap[14], cap[15], cap[16]} == 32'hCBF43926, "R3", "check string trailer",
          {cap[13], cap[14], cap[15], cap[16]}, 32'hCBF43926);
    if (idx == 3)  // R5 empty version-3 packet
      chk(ci == 8 && {cap[4], cap[5], cap[6], cap[7]} == 32'h0, "R5", "empty packet trailer",
          {cap[4], cap[5], cap[6], cap[7]}, 0);
    if (idx == 2)
      chk(ci == 4, "R5", "empty packet without trailer", ci, 4);
  endtask

  task automatic runRx(input vec_t v);
    int fi, oi, doneCnt, doneAt, lastAt, stallViol;
    bit err, okAll;
    fi = 0; oi = 0; doneCnt = 0; doneAt = -1; lastAt = -1; stallViol = 0; err = 1'b0;
    if (v.corrupt && v.ver == 2'd3) frame[flen-1] = frame[flen-1] ^ 8'h01;
    version = v.ver;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      rxInValid  = (fi < flen) && !(v.bp && (c % 5 == 2));
      rxInData   = frame[fi];
      rxOutReady = !(v.bp && (c % 3 == 1));
      #1;
      if (rxDone) begin doneCnt++; doneAt = c; err = rxCrcErr; end
      else if (rxCrcErr) err = 1'b1;
      if (rxOutValid && !rxOutReady && rxInReady) stallViol++;
      if (rxOutValid && rxOutReady) begin rcap[oi] = rxOutData; oi++; end
      if (rxInValid && rxInReady) begin fi++; if (fi == flen) lastAt = c; end
      if (lastAt >= 0 && c >= lastAt + 3) break;
    end
    @(negedge clk);
    rxInValid = 1'b0;
    okAll = (oi == int'(v.len));
    for (int k = 0; k < oi && k < 64; k++) if (rcap[k] !== pay[k]) okAll = 1'b0;
    chk(okAll, "R8", "recovered payload", oi, v.len);
    chk(doneCnt == 1 && doneAt == lastAt + 1, "R9", "completion pulse timing", doneAt, lastAt + 1);
    chk(err == (v.corrupt && v.ver == 2'd3), "R10", "mismatch flag", err, v.corrupt && v.ver == 2'd3);
    chk(stallViol == 0, "R11", "input taken while output stalled", stallViol, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=finish", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; version = 2'd1; txLenValid = 1'b0; txLen = '0; txInValid = 1'b0;
    txInData = '0; txOutReady = 1'b1; rxInValid = 1'b0; rxInData = '0; rxOutReady = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(txLenReady && !txOutValid && !rxOutValid && !rxDone && !rxCrcErr, "R12",
        "reset state", {txLenReady, txOutValid, rxOutValid, rxDone, rxCrcErr}, 5'b10000);

    for (int i = 0; i < NVEC; i++) begin
      buildFrame(VEC[i]);
      runTx(VEC[i], i);
      runRx(VEC[i]);
    end

    // directed: reset in the middle of a transmit frame returns to idle
    @(negedge clk);
    version = 2'd3; txLen = 32'd6; txLenValid = 1'b1; txOutReady = 1'b0;
    @(negedge clk);
    txLenValid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(txOutValid && !txLenReady, "R12", "busy before mid-frame reset", txOutValid, 1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1; txOutReady = 1'b1;
    #1;
    chk(txLenReady && !txOutValid, "R12", "idle after mid-frame reset", txOutValid, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule